// File: doc/BRIEF.md
# Latch-Switched Cartridge Bank Mapper

This block is the bank-switching logic of a game cartridge for an 8-bit console. It sits between the CPU bus, the pattern-fetch bus of the picture processor and the external program ROM, graphics ROM and work RAM. The CPU programs a handful of write-only registers by storing to the upper half of its address space. These registers select a switchable 16 KB program bank, four 5-bit graphics bank numbers and the nametable mirroring mode. The upper 16 KB program window is always mapped to the last bank.

Graphics banks are also switched without CPU help. Each 4 KB half of pattern space has a one-bit latch. The latch flips when the picture processor reads one of two small groups of tile addresses in that half. The latch then decides which of two bank registers drives that half. The triggering fetch is still served from the old bank, and the new bank applies from the next cycle on. All translation toward the ROMs and RAM is combinational. Register and latch updates take effect at the rising clock edge on which the write or read strobe is sampled.

Top module: `latch_bank_mapper`

## Requirements
- R1: A CPU address in 0xC000–0xFFFF is translated to the last program bank. `prg_rom_addr` is then all-ones bank bits followed by `cpu_addr[13:0]`.
- R2: A CPU write anywhere in 0xA000–0xAFFF loads the switchable program bank from `cpu_wdata[3:0]`. CPU addresses 0x8000–0xBFFF then map to that bank, keeping only its low `PRG_BANKS_LOG2` bits, so larger numbers wrap.
- R3: A CPU write in 0xB000–0xEFFF loads graphics register (addr−0xB000)>>12 (0xB→0, 0xC→1, 0xD→2, 0xE→3) from `cpu_wdata[4:0]`. Only its low `CHR_BANKS_LOG2` bits reach the ROM address.
- R4: A CPU write in 0xF000–0xFFFF sets `mirror_horiz` to `cpu_wdata[0]`, where 0 is vertical and 1 is horizontal.
- R5: `wram_sel` is high exactly for CPU addresses 0x6000–0x7FFF, with `wram_addr = cpu_addr[12:0]`. `prg_rom_sel` is high exactly for 0x8000–0xFFFF.
- R6: A PPU read (`ppu_rd`) at 0x0FD8–0x0FDF or 0x1FD8–0x1FDF clears latch `ppu_addr[12]`. A read at 0x0FE8–0x0FEF or 0x1FE8–0x1FEF sets it.
- R7: For PPU addresses below 0x2000, `chr_rom_addr` is the bank followed by `ppu_addr[11:0]`. The lower half (bit 12 = 0) uses register latch0, and the upper half uses register 2+latch1.
- R8: The fetch that changes a latch is still translated with the previous bank. The new bank applies from the following cycle.
- R9: Synchronous reset clears both latches, all four graphics registers and the program bank register, and selects vertical mirroring.
- R10: Other accesses change no state. This covers PPU reads next to the trigger groups (e.g. 0x0FD7), trigger addresses with `ppu_rd` low, and CPU writes to 0x8000–0x9FFF or to work RAM.
- R11: `chr_sel` is high exactly when `ppu_addr` is below 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising edge |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture-processor address |
| ppu_rd | input | 1 | Picture-processor read strobe, sampled at the rising edge |
| prg_rom_addr | output | 14+PRG_BANKS_LOG2 | Translated program ROM address |
| prg_rom_sel | output | 1 | Program ROM select |
| wram_addr | output | 13 | Work RAM address |
| wram_sel | output | 1 | Work RAM select |
| chr_rom_addr | output | 12+CHR_BANKS_LOG2 | Translated graphics ROM address |
| chr_sel | output | 1 | Graphics ROM select |
| mirror_horiz | output | 1 | Mirroring mode: 0 vertical, 1 horizontal |

## Verification
The bench builds the mapper with `PRG_BANKS_LOG2 = 3` and `CHR_BANKS_LOG2 = 4`, which is smaller than the register fields. With these values, a program bank of 15 wraps to 7, and a graphics value of 0x1A or 0x1F loses its top bit. This makes the masking of R2 and R3 observable. The eight-bank program ROM keeps the fixed window at bank 7, so a switchable bank of 7 and the fixed window can be compared directly.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    localparam int PRG_REG_W = 4;
    localparam int CHR_REG_W = 5;
    localparam int NUM_CHR_REGS = 4;
    localparam int NUM_HALVES = 2;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_PRG,
        WR_CHR,
        WR_MIRROR
    } wr_target_e;

    typedef enum logic {
        MIR_VERT  = 1'b0,
        MIR_HORIZ = 1'b1
    } mirror_e;

    typedef struct packed {
        wr_target_e target;
        logic [1:0] chr_idx;
    } wr_decode_t;

    typedef struct packed {
        logic valid;
        logic half;
        logic value;
    } latch_evt_t;

    function automatic wr_decode_t decode_write(input logic [15:0] addr);
        wr_decode_t d;
        d.target  = WR_NONE;
        d.chr_idx = 2'd0;
        unique case (addr[15:12])
            4'hA: d.target = WR_PRG;
            4'hB: begin d.target = WR_CHR; d.chr_idx = 2'd0; end
            4'hC: begin d.target = WR_CHR; d.chr_idx = 2'd1; end
            4'hD: begin d.target = WR_CHR; d.chr_idx = 2'd2; end
            4'hE: begin d.target = WR_CHR; d.chr_idx = 2'd3; end
            4'hF: d.target = WR_MIRROR;
            default: d.target = WR_NONE;
        endcase
        return d;
    endfunction

    function automatic latch_evt_t decode_fetch(input logic [13:0] addr, input logic rd);
        latch_evt_t e;
        logic in_pattern;
        logic grp_clear;
        logic grp_set;
        in_pattern = rd && !addr[13] && addr[3];
        grp_clear  = (addr[11:4] == 8'hFD);
        grp_set    = (addr[11:4] == 8'hFE);
        e.valid = in_pattern && (grp_clear || grp_set);
        e.half  = addr[12];
        e.value = grp_set;
        return e;
    endfunction

endpackage

// File: rtl/lbm_cpu_regs.sv
module lbm_cpu_regs
    import lbm_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   wr_en,
    input  logic [15:0]                            wr_addr,
    input  logic [7:0]                             wr_data,
    output logic [PRG_REG_W-1:0]                   prg_bank_q,
    output logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank_q,
    output mirror_e                                mirror_q
);
    wr_decode_t dec;

    always_comb dec = decode_write(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_bank_q <= '0;
            mirror_q   <= MIR_VERT;
        end else if (wr_en) begin
            if (dec.target == WR_PRG)
                prg_bank_q <= wr_data[PRG_REG_W-1:0];
            if (dec.target == WR_MIRROR)
                mirror_q <= mirror_e'(wr_data[0]);
        end
    end

    for (genvar g = 0; g < NUM_CHR_REGS; g++) begin : g_chr_reg
        always_ff @(posedge clk) begin
            if (rst)
                chr_bank_q[g] <= '0;
            else if (wr_en && dec.target == WR_CHR && dec.chr_idx == 2'(g))
                chr_bank_q[g] <= wr_data[CHR_REG_W-1:0];
        end
    end
endmodule

// File: rtl/lbm_pattern_latch.sv
module lbm_pattern_latch
    import lbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [13:0]           fetch_addr,
    input  logic                  fetch_rd,
    output logic [NUM_HALVES-1:0] lat_q
);
    latch_evt_t evt;

    always_comb evt = decode_fetch(fetch_addr, fetch_rd);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst)
                lat_q[h] <= 1'b0;
            else if (evt.valid && evt.half == 1'(h))
                lat_q[h] <= evt.value;
        end
    end
endmodule

// File: rtl/lbm_xlate.sv
module lbm_xlate
    import lbm_pkg::*;
#(
    parameter int PRG_BANKS_LOG2 = 4,
    parameter int CHR_BANKS_LOG2 = 5,
    localparam int PRG_AW = 14 + PRG_BANKS_LOG2,
    localparam int CHR_AW = 12 + CHR_BANKS_LOG2
) (
    input  logic [15:0]                            cpu_addr,
    input  logic [13:0]                            ppu_addr,
    input  logic [PRG_REG_W-1:0]                   prg_bank,
    input  logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank,
    input  logic [NUM_HALVES-1:0]                  lat,
    output logic [PRG_AW-1:0]                      prg_rom_addr,
    output logic                                   prg_rom_sel,
    output logic [12:0]                            wram_addr,
    output logic                                   wram_sel,
    output logic [CHR_AW-1:0]                      chr_rom_addr,
    output logic                                   chr_sel
);
    localparam logic [PRG_BANKS_LOG2-1:0] LAST_BANK = '1;

    logic [PRG_BANKS_LOG2-1:0] prg_eff;
    logic [NUM_HALVES-1:0][CHR_BANKS_LOG2-1:0] half_bank;

    always_comb begin
        prg_eff      = cpu_addr[14] ? LAST_BANK : prg_bank[PRG_BANKS_LOG2-1:0];
        prg_rom_addr = {prg_eff, cpu_addr[13:0]};
        prg_rom_sel  = cpu_addr[15];
        wram_sel     = (cpu_addr[15:13] == 3'b011);
        wram_addr    = cpu_addr[12:0];
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_win
        logic [CHR_REG_W-1:0] pick;
        always_comb begin
            pick = chr_bank[2 * h + int'(lat[h])];
            half_bank[h] = pick[CHR_BANKS_LOG2-1:0];
        end
    end

    always_comb begin
        chr_rom_addr = {half_bank[ppu_addr[12]], ppu_addr[11:0]};
        chr_sel      = !ppu_addr[13];
    end
endmodule

// File: rtl/latch_bank_mapper.sv
module latch_bank_mapper
    import lbm_pkg::*;
#(
    parameter int PRG_BANKS_LOG2 = 4,
    parameter int CHR_BANKS_LOG2 = 5,
    localparam int PRG_AW = 14 + PRG_BANKS_LOG2,
    localparam int CHR_AW = 12 + CHR_BANKS_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    input  logic [13:0]       ppu_addr,
    input  logic              ppu_rd,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_rom_sel,
    output logic [12:0]       wram_addr,
    output logic              wram_sel,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              chr_sel,
    output logic              mirror_horiz
);
    logic [PRG_REG_W-1:0]                   prg_bank_q;
    logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank_q;
    mirror_e                                mirror_q;
    logic [NUM_HALVES-1:0]                  lat_q;

    lbm_cpu_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cpu_wr),
        .wr_addr    (cpu_addr),
        .wr_data    (cpu_wdata),
        .prg_bank_q (prg_bank_q),
        .chr_bank_q (chr_bank_q),
        .mirror_q   (mirror_q)
    );

    lbm_pattern_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (ppu_addr),
        .fetch_rd   (ppu_rd),
        .lat_q      (lat_q)
    );

    lbm_xlate #(
        .PRG_BANKS_LOG2 (PRG_BANKS_LOG2),
        .CHR_BANKS_LOG2 (CHR_BANKS_LOG2)
    ) u_xlate (
        .cpu_addr     (cpu_addr),
        .ppu_addr     (ppu_addr),
        .prg_bank     (prg_bank_q),
        .chr_bank     (chr_bank_q),
        .lat          (lat_q),
        .prg_rom_addr (prg_rom_addr),
        .prg_rom_sel  (prg_rom_sel),
        .wram_addr    (wram_addr),
        .wram_sel     (wram_sel),
        .chr_rom_addr (chr_rom_addr),
        .chr_sel      (chr_sel)
    );

    assign mirror_horiz = (mirror_q == MIR_HORIZ);
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker
    import lbm_pkg::*;
#(
    parameter int PRG_BANKS_LOG2 = 4,
    parameter int CHR_BANKS_LOG2 = 5,
    localparam int PRG_AW = 14 + PRG_BANKS_LOG2,
    localparam int CHR_AW = 12 + CHR_BANKS_LOG2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [15:0]                            cpu_addr,
    input logic                                   cpu_wr,
    input logic [7:0]                             cpu_wdata,
    input logic [13:0]                            ppu_addr,
    input logic                                   ppu_rd,
    input logic [PRG_AW-1:0]                      prg_rom_addr,
    input logic                                   prg_rom_sel,
    input logic                                   wram_sel,
    input logic [CHR_AW-1:0]                      chr_rom_addr,
    input logic                                   mirror_horiz,
    input logic [NUM_HALVES-1:0]                  lat_q,
    input logic [NUM_CHR_REGS-1:0][CHR_REG_W-1:0] chr_bank_q
);
    logic trig_clear;
    logic trig_set;

    always_comb begin
        trig_clear = ppu_rd && !ppu_addr[13] && ppu_addr[11:3] == 9'h1FB;
        trig_set   = ppu_rd && !ppu_addr[13] && ppu_addr[11:3] == 9'h1FD;
    end

    a_r1_fixed_window: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b11) |-> (&prg_rom_addr[PRG_AW-1:14]));

    a_r4_mirror_write: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:12] == 4'hF) |=> (mirror_horiz == $past(cpu_wdata[0])));

    a_r5_select_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wram_sel && prg_rom_sel));

    a_r6_clear_group: assert property (@(posedge clk) disable iff (rst)
        trig_clear |=> !lat_q[$past(ppu_addr[12])]);

    a_r6_set_group: assert property (@(posedge clk) disable iff (rst)
        trig_set |=> lat_q[$past(ppu_addr[12])]);

    a_r10_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !(trig_clear || trig_set) |=> $stable(lat_q));

    a_r7_lower_window: assert property (@(posedge clk) disable iff (rst)
        (ppu_addr[13:12] == 2'b00) |->
            (chr_rom_addr[CHR_AW-1:12] == chr_bank_q[lat_q[0]][CHR_BANKS_LOG2-1:0]));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (lat_q == '0 && chr_bank_q == '0 && !mirror_horiz));
endmodule

bind latch_bank_mapper lbm_checker #(
    .PRG_BANKS_LOG2 (PRG_BANKS_LOG2),
    .CHR_BANKS_LOG2 (CHR_BANKS_LOG2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_wdata    (cpu_wdata),
    .ppu_addr     (ppu_addr),
    .ppu_rd       (ppu_rd),
    .prg_rom_addr (prg_rom_addr),
    .prg_rom_sel  (prg_rom_sel),
    .wram_sel     (wram_sel),
    .chr_rom_addr (chr_rom_addr),
    .mirror_horiz (mirror_horiz),
    .lat_q        (lat_q),
    .chr_bank_q   (chr_bank_q)
);

// File: tb/latch_bank_mapper_tb.sv
module latch_bank_mapper_tb;
    localparam int PL = 3;
    localparam int CL = 4;
    localparam int PAW = 14 + PL;
    localparam int CAW = 12 + CL;

    typedef enum int {K_PRG, K_CHR, K_WSEL, K_WADDR, K_PSEL, K_MIR, K_CSEL} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [13:0] ppu_addr = '0;
    logic ppu_rd = 1'b0;
    logic [PAW-1:0] prg_rom_addr;
    logic prg_rom_sel;
    logic [12:0] wram_addr;
    logic wram_sel;
    logic [CAW-1:0] chr_rom_addr;
    logic chr_sel;
    logic mirror_horiz;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    item_t sb[$];

    int m_prg;
    int m_chr[4];
    int m_lat[2];

    always #5 clk = ~clk;

    latch_bank_mapper #(.PRG_BANKS_LOG2(PL), .CHR_BANKS_LOG2(CL)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .ppu_rd(ppu_rd),
        .prg_rom_addr(prg_rom_addr), .prg_rom_sel(prg_rom_sel),
        .wram_addr(wram_addr), .wram_sel(wram_sel),
        .chr_rom_addr(chr_rom_addr), .chr_sel(chr_sel),
        .mirror_horiz(mirror_horiz)
    );

    // monitor: pop expected items and compare away from the rising edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_PRG:   act = 32'(prg_rom_addr);
                K_CHR:   act = 32'(chr_rom_addr);
                K_WSEL:  act = 32'(wram_sel);
                K_WADDR: act = 32'(wram_addr);
                K_PSEL:  act = 32'(prg_rom_sel);
                K_MIR:   act = 32'(mirror_horiz);
                default: act = 32'(chr_sel);
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] prg_exp(input logic [15:0] a);
        int b;
        b = a[14] ? (1 << PL) - 1 : (m_prg & ((1 << PL) - 1));
        return (32'(b) << 14) | 32'(a[13:0]);
    endfunction

    function automatic logic [31:0] chr_exp(input logic [13:0] a);
        int r;
        r = a[12] ? m_chr[2 + m_lat[1]] : m_chr[m_lat[0]];
        return (32'(r & ((1 << CL) - 1)) << 12) | 32'(a[11:0]);
    endfunction

    task automatic push(input kind_e k, input logic [31:0] e, input string req);
        item_t it;
        it.kind = k; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step_drive();
        @(posedge clk); #2;
        cpu_wr = 1'b0;
        ppu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        step_drive();
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        if (a[15:12] == 4'hA) m_prg = int'(d[3:0]);
        else if (a[15:12] >= 4'hB && a[15:12] <= 4'hE) m_chr[a[15:12] - 4'hB] = int'(d[4:0]);
    endtask

    task automatic cpu_look(input logic [15:0] a, input string req);
        step_drive();
        cpu_addr = a;
        push(K_PRG, prg_exp(a), req);
    endtask

    task automatic ppu_fetch(input logic [13:0] a, input logic rd, input string req);
        step_drive();
        ppu_addr = a; ppu_rd = rd;
        push(K_CHR, chr_exp(a), req);
        if (rd && !a[13] && a[3] && a[11:4] == 8'hFD) m_lat[a[12]] = 0;
        if (rd && !a[13] && a[3] && a[11:4] == 8'hFE) m_lat[a[12]] = 1;
    endtask

    task automatic do_reset();
        step_drive();
        rst = 1'b1;
        step_drive();
        step_drive();
        rst = 1'b0;
        m_prg = 0; m_chr = '{0, 0, 0, 0}; m_lat = '{0, 0};
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 reset state
        cpu_look(16'h8123, "R9 prg bank after reset");
        ppu_fetch(14'h0456, 1'b0, "R9 chr bank after reset");
        ppu_fetch(14'h1456, 1'b0, "R9 upper chr after reset");
        push(K_MIR, 0, "R9 mirroring vertical after reset");

        // R2 switchable bank and wrap
        cpu_write(16'hA000, 8'h05);
        cpu_look(16'h8010, "R2 bank 5");
        cpu_look(16'hBFFF, "R2 bank 5 top");
        cpu_write(16'hAFFF, 8'h0F);
        cpu_look(16'h9ABC, "R2 bank 15 wraps to 7");
        cpu_write(16'hA800, 8'hF2);
        cpu_look(16'h8000, "R2 upper data bits ignored");

        // R1 fixed window
        cpu_look(16'hC000, "R1 fixed bottom");
        cpu_look(16'hFFFF, "R1 fixed top");

        // R3 graphics registers
        cpu_write(16'hB000, 8'h03);
        cpu_write(16'hC7FF, 8'h1A);
        cpu_write(16'hD123, 8'h07);
        cpu_write(16'hEFFF, 8'hFF);
        ppu_fetch(14'h0100, 1'b0, "R3 R7 lower uses reg0");
        ppu_fetch(14'h1100, 1'b0, "R3 R7 upper uses reg2");

        // R6/R8 set latches
        ppu_fetch(14'h0FE8, 1'b1, "R8 trigger read uses old bank lower");
        ppu_fetch(14'h0010, 1'b0, "R6 R7 lower uses reg1 after set");
        ppu_fetch(14'h1FEF, 1'b1, "R8 trigger read uses old bank upper");
        ppu_fetch(14'h1000, 1'b0, "R6 R7 upper uses reg3 after set");
        ppu_fetch(14'h0FFF, 1'b0, "R6 lower still set");

        // R10 near-miss and no-strobe
        ppu_fetch(14'h0FD7, 1'b1, "R10 adjacent read");
        ppu_fetch(14'h0200, 1'b0, "R10 latch kept after 0x0FD7");
        ppu_fetch(14'h0FF0, 1'b1, "R10 read past set group");
        ppu_fetch(14'h0200, 1'b0, "R10 latch kept after 0x0FF0");
        ppu_fetch(14'h0FD8, 1'b1, "R8 clear trigger uses old bank");
        ppu_fetch(14'h0200, 1'b0, "R6 lower cleared");
        ppu_fetch(14'h0FE8, 1'b0, "R10 trigger address without strobe");
        ppu_fetch(14'h0200, 1'b0, "R10 no strobe keeps latch");
        ppu_fetch(14'h1FDC, 1'b1, "R8 upper clear trigger");
        ppu_fetch(14'h1ABC, 1'b0, "R6 upper cleared");
        ppu_fetch(14'h2FE8, 1'b1, "R10 nametable read");
        ppu_fetch(14'h1ABC, 1'b0, "R10 upper kept after 0x2FE8");

        // R4 mirroring
        cpu_write(16'hF000, 8'h01);
        step_drive();
        push(K_MIR, 1, "R4 horizontal");
        cpu_write(16'hFFFE, 8'hFE);
        step_drive();
        push(K_MIR, 0, "R4 vertical");

        // R10 CPU writes elsewhere
        cpu_write(16'h9000, 8'h02);
        cpu_look(16'h8000, "R10 write to 0x9000 ignored");
        cpu_write(16'h6001, 8'h01);
        step_drive();
        push(K_MIR, 0, "R10 work RAM write leaves mirroring");
        cpu_addr = 16'h8000;
        push(K_PRG, prg_exp(16'h8000), "R10 work RAM write leaves bank");

        // R5 selects
        step_drive(); cpu_addr = 16'h6000;
        push(K_WSEL, 1, "R5 wram low"); push(K_WADDR, 0, "R5 wram addr low");
        push(K_PSEL, 0, "R5 rom sel off in wram");
        step_drive(); cpu_addr = 16'h7FFF;
        push(K_WSEL, 1, "R5 wram high"); push(K_WADDR, 13'h1FFF, "R5 wram addr high");
        step_drive(); cpu_addr = 16'h5FFF;
        push(K_WSEL, 0, "R5 below wram"); push(K_PSEL, 0, "R5 below rom");
        step_drive(); cpu_addr = 16'h8000;
        push(K_WSEL, 0, "R5 wram off in rom"); push(K_PSEL, 1, "R5 rom sel");

        // R11
        step_drive(); ppu_addr = 14'h1FFF; push(K_CSEL, 1, "R11 pattern top");
        step_drive(); ppu_addr = 14'h2000; push(K_CSEL, 0, "R11 nametable");

        // R9 second reset after changes
        ppu_fetch(14'h0FE9, 1'b1, "R6 set before reset");
        cpu_write(16'hF000, 8'h01);
        do_reset();
        ppu_fetch(14'h0300, 1'b0, "R9 latch and regs cleared");
        cpu_look(16'h8300, "R9 prg bank cleared");
        push(K_MIR, 0, "R9 mirroring cleared");

        step_drive();
        step_drive();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule